// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog timer reached through a small word-wide register port. Software places a reload value in the load register and sets the run bit in the control register. A down-counter then decrements once per pulse of an external tick-enable strobe. To keep the system alive, software must write a fixed key word to the restart register before the count runs out. Writes with any other data, or any restart write while the timer is stopped, do nothing.

When the counter decrements to zero, a sticky expiry flag is set and the counter holds at zero. Two independent control bits decide what the expiry does. One drives a level interrupt that follows the flag. The other produces a one-cycle system-reset request. Clearing the run bit freezes the count and cancels any expiry that was pending. Setting the run bit again after that restarts the count from the load value.

Read accesses return data one cycle after the strobe. Reads of unmapped offsets return zero, and writes to them are dropped.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, control reads 0, status reads 0, load reads 0x03EF1480, `irq` is 0 and `sys_rst_req` is 0.
- R2: A read strobe gives `bus_rvalid` high and `bus_rdata` valid one cycle later. The byte offsets are 0x00 count, 0x04 load, 0x0C control (bits 2:0), 0x10 status (bit 0) and 0x1C revision, which reads 0x00010601. Any other offset, or any address with a bit above bit 7 set, reads 0, and writes to it are ignored.
- R3: Control bit 0 is run, bit 1 is reset enable and bit 2 is interrupt enable. A control write with bit 0 set while stopped starts the counter from the load value.
- R4: A control write with bit 0 set while already running leaves the count unchanged.
- R5: A write of 0x00005AB9 to offset 0x08 while running reloads the count from load. Any other data, or the same write while stopped, leaves the count unchanged.
- R6: While running, each cycle with `tick_en` high lowers a nonzero count by one. Offset 0x00 reads the live count while running and the load value while stopped.
- R7: A decrement from 1 to 0 sets status bit 0. The count then stays at 0 and does not set the flag or request a reset again until it is reloaded.
- R8: `irq` is high exactly when status bit 0 and control bit 2 are both 1.
- R9: `sys_rst_req` is a one-cycle pulse in the cycle after the expiring edge, issued only if control bit 1 was set at that edge.
- R10: A control write with bit 0 clear stops the count. Ticks then neither change the count nor cause an expiry, and this includes a tick in the same cycle as the write.
- R11: Any write to offset 0x14 clears status bit 0. If an expiry happens in the same cycle, the flag ends up set.
- R12: A write to offset 0x04 changes the load value but not a running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-down strobe, one decrement per high cycle |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High one cycle after `bus_rd` |
| irq | output | 1 | Level interrupt |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Register writes, reloads and decrements take effect at the clock edge that samples the strobe. Read data arrives one edge after `bus_rd`. The expiry flag and `irq` change at the same edge that takes the count from 1 to 0, and `sys_rst_req` is high only in the cycle after that edge. The bench drives strobes on falling edges and samples every output on the next falling edge. A read task queues the expected word, and a monitor pops that word only when `bus_rvalid` is high, so each read is compared in its own latency slot. Tick bursts are sized so the expiring edge is the last one, and the pulse and interrupt checks land on it and the cycle after it.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned OFS_W  = 8;

    localparam logic [OFS_W-1:0] OFS_COUNT = 8'h00;
    localparam logic [OFS_W-1:0] OFS_LOAD  = 8'h04;
    localparam logic [OFS_W-1:0] OFS_KICK  = 8'h08;
    localparam logic [OFS_W-1:0] OFS_CTRL  = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_STAT  = 8'h10;
    localparam logic [OFS_W-1:0] OFS_CLR   = 8'h14;
    localparam logic [OFS_W-1:0] OFS_REV   = 8'h1C;

    localparam logic [WORD_W-1:0] KICK_KEY  = 32'h0000_5AB9;
    localparam logic [WORD_W-1:0] REV_WORD  = 32'h0001_0601;
    localparam logic [WORD_W-1:0] LOAD_INIT = 32'h03EF_1480;

    typedef struct packed {
        logic irq_en;
        logic rst_en;
        logic run_en;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_LOAD,
        SEL_KICK,
        SEL_CTRL,
        SEL_STAT,
        SEL_CLR,
        SEL_REV
    } reg_sel_e;

    typedef struct packed {
        logic load;
        logic kick;
        logic ctrl;
        logic clr;
    } wr_hit_t;

    function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_COUNT: return SEL_COUNT;
            OFS_LOAD:  return SEL_LOAD;
            OFS_KICK:  return SEL_KICK;
            OFS_CTRL:  return SEL_CTRL;
            OFS_STAT:  return SEL_STAT;
            OFS_CLR:   return SEL_CLR;
            OFS_REV:   return SEL_REV;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              status,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  load_q,
    output logic              reload,
    output logic              run_ok,
    output logic              clr_stat,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid
);

    logic        in_win;
    reg_sel_e    sel;
    wr_hit_t     hit;
    logic        starting;
    logic        stopping;
    logic        kick_ok;
    logic [WORD_W-1:0] rd_word;

    generate
        if (ADDR_W > OFS_W) begin : g_hi
            assign in_win = (bus_addr[ADDR_W-1:OFS_W] == '0);
        end else begin : g_flat
            assign in_win = 1'b1;
        end
    endgenerate

    assign sel = in_win ? decode_ofs(bus_addr[OFS_W-1:0]) : SEL_NONE;

    always_comb begin
        hit      = '0;
        hit.load = bus_wr && (sel == SEL_LOAD);
        hit.kick = bus_wr && (sel == SEL_KICK);
        hit.ctrl = bus_wr && (sel == SEL_CTRL);
        hit.clr  = bus_wr && (sel == SEL_CLR);
    end

    assign starting = hit.ctrl && bus_wdata[0] && !ctrl_q.run_en;
    assign stopping = hit.ctrl && !bus_wdata[0];
    assign kick_ok  = hit.kick && ctrl_q.run_en && (bus_wdata == KICK_KEY);
    assign reload   = starting || kick_ok;
    assign run_ok   = ctrl_q.run_en && !stopping;
    assign clr_stat = hit.clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= LOAD_INIT[CNT_W-1:0];
        end else begin
            if (hit.ctrl) ctrl_q <= ctrl_t'(bus_wdata[2:0]);
            if (hit.load) load_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        case (sel)
            SEL_COUNT: rd_word = WORD_W'(ctrl_q.run_en ? count : load_q);
            SEL_LOAD:  rd_word = WORD_W'(load_q);
            SEL_CTRL:  rd_word = WORD_W'(ctrl_q);
            SEL_STAT:  rd_word = WORD_W'(status);
            SEL_REV:   rd_word = REV_WORD;
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             fire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;

    assign step = run && tick && !reload && (count != '0);
    assign fire = step && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst)         count <= '0;
        else if (reload) count <= load_val;
        else if (step)   count <= count - ONE;
    end

endmodule

// File: rtl/kwd_action.sv
module kwd_action (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic clr,
    input  logic irq_en,
    input  logic rst_en,
    output logic status,
    output logic irq,
    output logic sys_rst_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status      <= 1'b0;
            sys_rst_req <= 1'b0;
        end else begin
            if (fire)     status <= 1'b1;
            else if (clr) status <= 1'b0;
            sys_rst_req <= fire && rst_en;
        end
    end

    assign irq = status && irq_en;

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              irq,
    output logic              sys_rst_req
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt_q;
    logic             reload;
    logic             run_ok;
    logic             clr_stat;
    logic             fire;
    logic             status;

    kwd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .count      (cnt_q),
        .status     (status),
        .ctrl_q     (ctrl_q),
        .load_q     (load_q),
        .reload     (reload),
        .run_ok     (run_ok),
        .clr_stat   (clr_stat),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    kwd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run_ok),
        .tick     (tick_en),
        .reload   (reload),
        .load_val (load_q),
        .count    (cnt_q),
        .fire     (fire)
    );

    kwd_action u_act (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .clr         (clr_stat),
        .irq_en      (ctrl_q.irq_en),
        .rst_en      (ctrl_q.rst_en),
        .status      (status),
        .irq         (irq),
        .sys_rst_req (sys_rst_req)
    );

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
    import kwd_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic              sys_rst_req,
    input logic              rst_en,
    input logic              status,
    input logic              clr_stat,
    input logic [CNT_W-1:0]  count,
    input logic              reload,
    input logic              run,
    input logic              tick
);

    localparam logic [ADDR_W-1:0] REV_ADDR = ADDR_W'(OFS_REV);

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid); // R2

    AST_REV_WORD: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == REV_ADDR) |=> (bus_rdata == REV_WORD)); // R2

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !reload && count != '0) |=> (count == $past(count) - CNT_W'(1))); // R6

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !reload) |=> (count == '0)); // R7

    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!run && !reload) |=> $stable(count)); // R10

    AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |=> !sys_rst_req); // R9

    AST_RST_GATED: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> ($past(rst_en) && status)); // R9

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status && !clr_stat) |=> status); // R11

endmodule

bind keyed_watchdog kwd_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .sys_rst_req (sys_rst_req),
    .rst_en      (ctrl_q.rst_en),
    .status      (status),
    .clr_stat    (clr_stat),
    .count       (cnt_q),
    .reload      (reload),
    .run         (run_ok),
    .tick        (tick_en)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

    localparam int unsigned ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_en = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic              irq;
    logic              sys_rst_req;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    keyed_watchdog #(.ADDR_W(ADDR_W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (tick_en),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_rvalid  (bus_rvalid),
        .irq         (irq),
        .sys_rst_req (sys_rst_req)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // monitor: pops one expected word per valid read
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (q_exp.size() == 0) begin
                check("R2 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                check(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_tick(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check("watchdog expired", 32'd1, 32'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq after reset", 32'(irq), 32'd0);
        check("R1 sys_rst_req after reset", 32'(sys_rst_req), 32'd0);
        rd(12'h00C, 32'd0, "R1 control after reset");
        rd(12'h010, 32'd0, "R1 status after reset");
        rd(12'h004, 32'h03EF1480, "R1 load after reset");
        rd(12'h000, 32'h03EF1480, "R6 count reads load while stopped");
        rd(12'h01C, 32'h00010601, "R2 revision word");
        rd(12'h018, 32'd0, "R2 unmapped offset reads zero");

        // R2 unmapped writes ignored, high address bits alias nothing
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h104, 32'd77);
        rd(12'h020, 32'd0, "R2 write to unmapped offset ignored");
        rd(12'h104, 32'd0, "R2 high address bit reads zero");
        rd(12'h004, 32'h03EF1480, "R2 high address write left load alone");

        wr(12'h004, 32'd10);
        // R5 key while stopped has no effect
        wr(12'h008, 32'h5AB9);
        rd(12'h010, 32'd0, "R5 key while stopped no expiry state");

        // R3 start reloads
        wr(12'h00C, 32'd1);
        rd(12'h000, 32'd10, "R3 start loads count");
        ticks(3);
        rd(12'h000, 32'd7, "R6 three ticks");
        // R4 rewrite while running
        wr(12'h00C, 32'd1);
        rd(12'h000, 32'd7, "R4 rewrite run bit no reload");
        // R5 wrong key, right key
        wr(12'h008, 32'h1234);
        rd(12'h000, 32'd7, "R5 wrong key ignored");
        wr(12'h008, 32'h5AB9);
        rd(12'h000, 32'd10, "R5 key reloads");
        // R12 load write while running
        wr(12'h004, 32'd20);
        rd(12'h000, 32'd10, "R12 running count untouched");
        rd(12'h004, 32'd20, "R12 load updated");

        // R7/R8/R9 expiry with reset and irq enabled
        wr(12'h00C, 32'd7);
        rd(12'h00C, 32'd7, "R3 control readback");
        ticks(9);
        check("R8 irq before expiry", 32'(irq), 32'd0);
        rd(12'h000, 32'd1, "R6 count one before expiry");
        ticks(1);
        check("R9 reset pulse at expiry", 32'(sys_rst_req), 32'd1);
        check("R8 irq at expiry", 32'(irq), 32'd1);
        @(negedge clk);
        check("R9 reset pulse one cycle", 32'(sys_rst_req), 32'd0);
        rd(12'h010, 32'd1, "R7 status set");
        rd(12'h000, 32'd0, "R7 count at zero");
        tick_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R7 no refire at zero", 32'(sys_rst_req), 32'd0);
        end
        tick_en = 1'b0;
        rd(12'h000, 32'd0, "R7 count holds zero");

        // R11 clear
        wr(12'h014, 32'hDEAD);
        check("R8 irq drops after clear", 32'(irq), 32'd0);
        rd(12'h010, 32'd0, "R11 status cleared");

        // R9 no reset pulse when bit 1 clear
        wr(12'h008, 32'h5AB9);
        wr(12'h00C, 32'd5);
        ticks(20);
        check("R9 no pulse when disabled", 32'(sys_rst_req), 32'd0);
        check("R8 irq with enable", 32'(irq), 32'd1);
        @(negedge clk);
        check("R9 no pulse next cycle", 32'(sys_rst_req), 32'd0);
        wr(12'h00C, 32'd1);
        check("R8 irq masked by control", 32'(irq), 32'd0);
        rd(12'h010, 32'd1, "R8 status still set when masked");
        wr(12'h014, 32'd0);

        // R10 stop freezes
        wr(12'h008, 32'h5AB9);
        ticks(5);
        rd(12'h000, 32'd15, "R6 five ticks from twenty");
        wr(12'h00C, 32'd0);
        rd(12'h000, 32'd20, "R6 stopped reads load");
        ticks(30);
        rd(12'h010, 32'd0, "R10 no expiry while stopped");
        wr(12'h00C, 32'd1);
        rd(12'h000, 32'd20, "R3 restart reloads from load");

        // R10 stop in the same cycle as the final tick
        wr(12'h004, 32'd1);
        wr(12'h00C, 32'd0);
        wr(12'h00C, 32'd1);
        wr_tick(12'h00C, 32'd0);
        rd(12'h010, 32'd0, "R10 stop cancels expiry on same tick");

        // R11 set wins over clear
        wr(12'h00C, 32'd1);
        rd(12'h000, 32'd1, "R3 count one");
        wr_tick(12'h014, 32'd0);
        rd(12'h010, 32'd1, "R11 expiry wins over clear");
        check("R8 irq off without enable", 32'(irq), 32'd0);

        repeat (3) @(negedge clk);
        check("R2 all reads returned", 32'(q_exp.size()), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule